// File: doc/BRIEF.md
# Multi-Channel Debounced Input Interrupt Controller

This block watches up to eight input-only lines that arrive with no relation to the system clock. It brings each line into the clock domain, then filters it with a debounce window that each channel sets for itself in whole milliseconds. A new level is reported as stable only after it has held for the full window. Anything shorter is dropped.

When a stable level matches the channel's chosen trigger polarity, the block latches one event in a sticky status bit. All masked status bits combine into one registered interrupt. A free-running divider turns the system clock into a one-millisecond enable, so the window is set in milliseconds and not in clock cycles.

A flat register port gives software access to each channel's window, polarity and enable, to a shared mask, and to a write-one-to-clear status register. The block also drives a request for its clock to be shut off. This request is high only when no channel is counting and no enabled channel has a pending difference.

Top module: `dbi_ctrl`

## Requirements
- R1: After a synchronized level change on an enabled channel with effective window W ms, the new level appears on `stable_lvl` at the (W+1)-th millisecond tick after counting starts. The level must therefore have held for at least W ms and at most W+1 ms.
- R2: A level held for less than one millisecond never changes `stable_lvl` and never sets status.
- R3: Any change of the synchronized level while the window is running restarts the count from zero, measured from the latest change.
- R4: The window field sits in bits [11:0] of the channel configuration word. A value of 0 behaves as 1 ms, and any value above 4000 behaves as 4000 ms.
- R5: Bit 12 of the configuration word selects the trigger polarity: 1 selects high and 0 selects low. A status bit is set only when the newly qualified stable level equals that polarity.
- R6: Status bits are sticky, which gives one event per qualified transition. Status is read at address 9. Writing a 1 to a bit there clears it. A held level never sets status again, and a new set wins over a clear in the same cycle.
- R7: `irq` is a register that follows the OR of (status AND mask) one cycle later. The mask is at address 8.
- R8: Bit 13 of the configuration word enables the channel. A disabled channel keeps its last stable level and never sets status.
- R9: `clk_off_req` is high only when no channel is counting and no enabled channel has a synchronized level that differs from its stable level. It falls within one cycle of such a synchronized change.
- R10: Channel n's configuration is at address n. After reset, all configuration, mask, status, `stable_lvl` and `irq` are zero, `clk_off_req` is high, and every register reads back what was written.
- R11: The millisecond tick is a single-cycle pulse once every CLK_HZ/TICK_HZ clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_async | input | NCH | Raw external input lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 14 | Register write data |
| reg_rdata | output | 14 | Register read data (combinational) |
| irq | output | 1 | Shared interrupt, registered |
| stable_lvl | output | NCH | Debounced level per channel |
| clk_off_req | output | 1 | Request to shut off the block clock |

## Verification
The bench builds the block with NCH=4, CLK_HZ=10000 and TICK_HZ=1000, so one millisecond lasts ten clocks. With this setting even the clamped 4000 ms window completes in about forty thousand cycles, and the full legal window range can be checked end to end. Short pulses sent at several tick phases make the sub-millisecond rejection independent of where the free-running divider happens to be. The scoreboard compares every change on `stable_lvl` against a time window computed from the programmed value.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
   localparam int CFG_W     = 14;
   localparam int DLY_W     = 12;
   localparam int ADDR_W    = 4;
   localparam int DLY_MAX   = 4000;

   localparam logic [ADDR_W-1:0] A_MASK = 4'h8;
   localparam logic [ADDR_W-1:0] A_STAT = 4'h9;
   localparam logic [ADDR_W-1:0] A_LVL  = 4'hA;

   typedef struct packed {
      logic             en;
      logic             trig_hi;
      logic [DLY_W-1:0] dly;
   } chan_cfg_t;

   function automatic logic [DLY_W-1:0] eff_dly(input logic [DLY_W-1:0] d);
      if (d == '0)
         return DLY_W'(1);
      else if (d > DLY_W'(DLY_MAX))
         return DLY_W'(DLY_MAX);
      else
         return d;
   endfunction
endpackage

// File: rtl/dbi_tick.sv
module dbi_tick #(
   parameter int DIV = 50000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   initial begin
      if (DIV < 2) $error("dbi_tick: DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (cnt_q == CW'(DIV - 1)) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         tick  <= 1'b0;
      end
   end
endmodule

// File: rtl/dbi_sync.sv
module dbi_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      if (STAGES < 2) $error("dbi_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dbi_chan.sv
module dbi_chan
   import dbi_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      lvl,
   input  chan_cfg_t cfg,
   output logic      stable,
   output logic      busy,
   output logic      evt
);
   logic [DLY_W-1:0] cnt_q;
   logic [DLY_W-1:0] lim;
   logic             prev_q;
   logic             chg;
   logic             hit;

   assign lim = eff_dly(cfg.dly);
   assign chg = (lvl != prev_q);
   assign hit = cfg.en & busy & ~chg & tick & (cnt_q == lim);
   assign evt = hit & (lvl == cfg.trig_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         stable <= 1'b0;
         busy   <= 1'b0;
         cnt_q  <= '0;
      end else begin
         prev_q <= lvl;
         if (!cfg.en) begin
            busy  <= 1'b0;
            cnt_q <= '0;
         end else if (chg) begin
            busy  <= (lvl != stable);
            cnt_q <= '0;
         end else if (!busy) begin
            if (lvl != stable) begin
               busy  <= 1'b1;
               cnt_q <= '0;
            end
         end else if (tick) begin
            if (cnt_q == lim) begin
               stable <= lvl;
               busy   <= 1'b0;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dbi_ctrl.sv
module dbi_ctrl
   import dbi_pkg::*;
#(
   parameter int NCH         = 8,
   parameter int CLK_HZ      = 50_000_000,
   parameter int TICK_HZ     = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    in_async,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [CFG_W-1:0]  reg_wdata,
   output logic [CFG_W-1:0]  reg_rdata,
   output logic              irq,
   output logic [NCH-1:0]    stable_lvl,
   output logic              clk_off_req
);
   localparam int DIV = CLK_HZ / TICK_HZ;

   initial begin
      if (NCH < 1 || NCH > 8) $error("dbi_ctrl: NCH must be 1..8");
      if (DIV < 2)            $error("dbi_ctrl: CLK_HZ/TICK_HZ must be >= 2");
   end

   logic              tick;
   logic [NCH-1:0]    sync_v;
   logic [NCH-1:0]    busy_v;
   logic [NCH-1:0]    evt_v;
   logic [NCH-1:0]    en_v;
   logic [NCH-1:0]    trig_v;
   logic [NCH-1:0]    mask_q;
   logic [NCH-1:0]    status_q;
   logic [NCH-1:0]    clr_v;
   logic [CFG_W-1:0]  cfg_q [NCH];

   dbi_tick #(.DIV(DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      chan_cfg_t cfg;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg_q[i] <= '0;
         else if (reg_wr && reg_addr == ADDR_W'(i))
            cfg_q[i] <= reg_wdata;
      end

      assign cfg       = chan_cfg_t'(cfg_q[i]);
      assign en_v[i]   = cfg.en;
      assign trig_v[i] = cfg.trig_hi;

      dbi_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (in_async[i]),
         .q     (sync_v[i])
      );

      dbi_chan u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .lvl    (sync_v[i]),
         .cfg    (cfg),
         .stable (stable_lvl[i]),
         .busy   (busy_v[i]),
         .evt    (evt_v[i])
      );
   end

   assign clr_v = (reg_wr && reg_addr == A_STAT) ? reg_wdata[NCH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q   <= '0;
         status_q <= '0;
         irq      <= 1'b0;
      end else begin
         if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[NCH-1:0];
         status_q <= (status_q & ~clr_v) | evt_v;
         irq      <= |(status_q & mask_q);
      end
   end

   assign clk_off_req = ~(|busy_v) & ~(|(en_v & (sync_v ^ stable_lvl)));

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NCH; i++) begin
         if (reg_addr == ADDR_W'(i)) reg_rdata = cfg_q[i];
      end
      case (reg_addr)
         A_MASK:  reg_rdata = CFG_W'(mask_q);
         A_STAT:  reg_rdata = CFG_W'(status_q);
         A_LVL:   reg_rdata = CFG_W'(stable_lvl);
         default: ;
      endcase
   end
endmodule

// File: rtl/dbi_chk.sv
module dbi_chk #(
   parameter int NCH = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           tick,
   input logic           irq,
   input logic           clk_off_req,
   input logic [NCH-1:0] busy_v,
   input logic [NCH-1:0] en_v,
   input logic [NCH-1:0] trig_v,
   input logic [NCH-1:0] status_q,
   input logic [NCH-1:0] mask_q,
   input logic [NCH-1:0] clr_v,
   input logic [NCH-1:0] stable_lvl
);
   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R11

   AST_IRQ_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past(|(status_q & mask_q)))); // R7

   AST_OFF_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      clk_off_req |-> (busy_v == '0)); // R9

   for (genvar i = 0; i < NCH; i++) begin : g_a
      AST_WAKE_BEFORE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(busy_v[i]) |-> $past(!clk_off_req)); // R9

      AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (status_q[i] && !clr_v[i]) |=> status_q[i]); // R6

      AST_SET_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(status_q[i]) |-> (stable_lvl[i] == trig_v[i])); // R5

      AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(stable_lvl[i]) |-> $past(en_v[i])); // R8
   end
endmodule

bind dbi_ctrl dbi_chk #(.NCH(NCH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .irq         (irq),
   .clk_off_req (clk_off_req),
   .busy_v      (busy_v),
   .en_v        (en_v),
   .trig_v      (trig_v),
   .status_q    (status_q),
   .mask_q      (mask_q),
   .clr_v       (clr_v),
   .stable_lvl  (stable_lvl)
);

// File: tb/sim_dbi_ctrl.sv
module sim_dbi_ctrl;
   localparam int NCH = 4;
   localparam int DIV = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH-1:0]    in_async = '0;
   logic              reg_wr = 1'b0;
   logic [3:0]        reg_addr = '0;
   logic [13:0]       reg_wdata = '0;
   logic [13:0]       reg_rdata;
   logic              irq;
   logic [NCH-1:0]    stable_lvl;
   logic              clk_off_req;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;

   typedef struct {
      int ch;
      int lvl;
      int lo;
      int hi;
   } exp_t;
   exp_t sb[$];

   dbi_ctrl #(.NCH(NCH), .CLK_HZ(10000), .TICK_HZ(1000), .SYNC_STAGES(2)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_async    (in_async),
      .reg_wr      (reg_wr),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .irq         (irq),
      .stable_lvl  (stable_lvl),
      .clk_off_req (clk_off_req)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [13:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output int v);
      @(negedge clk);
      reg_addr = a;
      #1 v = int'(reg_rdata);
   endtask

   task automatic push_exp(input int ch, input int lvl, input int lim);
      exp_t e;
      e.ch = ch; e.lvl = lvl;
      e.lo = cyc + lim * DIV + 2;
      e.hi = cyc + (lim + 1) * DIV + 8;
      sb.push_back(e);
   endtask

   task automatic drive_exp(input int ch, input int lvl, input int lim);
      @(negedge clk);
      push_exp(ch, lvl, lim);
      in_async[ch] = lvl[0];
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: every change of a stable level must match the head of the queue
   logic [NCH-1:0] prev_lvl = '0;
   always @(negedge clk) begin
      if (mon_on) begin
         for (int c = 0; c < NCH; c++) begin
            if (stable_lvl[c] != prev_lvl[c]) begin
               if (sb.size() == 0) begin
                  chk(1'b0, "R2", "unexpected stable change on channel", c, -1);
               end else begin
                  exp_t e;
                  e = sb.pop_front();
                  chk(e.ch == c, "R1", "channel of stable change", c, e.ch);
                  chk(int'(stable_lvl[c]) == e.lvl, "R1", "new stable level", int'(stable_lvl[c]), e.lvl);
                  chk(cyc >= e.lo && cyc <= e.hi, "R1", "cycle of stable change (vs latest)", cyc, e.hi);
               end
            end
         end
         prev_lvl = stable_lvl;
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "R1", "watchdog expired", cyc, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin : main
      int v;
      waitc(3);
      rst_n = 1'b1;
      waitc(2);
      mon_on = 1'b1;

      // R10 reset state
      chk(irq == 1'b0, "R10", "irq after reset", int'(irq), 0);
      chk(clk_off_req == 1'b1, "R10", "clk_off_req after reset", int'(clk_off_req), 1);
      chk(stable_lvl == '0, "R10", "stable_lvl after reset", int'(stable_lvl), 0);
      rd(4'h9, v); chk(v == 0, "R10", "status after reset", v, 0);
      rd(4'h0, v); chk(v == 0, "R10", "cfg0 after reset", v, 0);

      // R10 register readback
      wr(4'h8, 14'h000F);
      wr(4'h0, 14'h3003);
      rd(4'h0, v); chk(v == 'h3003, "R10", "cfg0 readback", v, 'h3003);
      rd(4'h8, v); chk(v == 'hF, "R10", "mask readback", v, 'hF);
      chk(clk_off_req == 1'b1, "R9", "idle enabled channel allows clock off", int'(clk_off_req), 1);

      // R1 / R9: rise on ch0, window 3 ms, trigger high
      drive_exp(0, 1, 3);
      waitc(3);
      chk(clk_off_req == 1'b0, "R9", "clk_off_req drops on change", int'(clk_off_req), 0);
      waitc(5 * DIV);
      rd(4'h9, v); chk(v == 1, "R5", "status after high qualify", v, 1);
      chk(irq == 1'b1, "R7", "irq with masked-in status", int'(irq), 1);
      chk(clk_off_req == 1'b1, "R9", "clk_off_req back after settle", int'(clk_off_req), 1);

      // R6 clear, then held level must not retrigger
      wr(4'h9, 14'h0001);
      waitc(1);
      rd(4'h9, v); chk(v == 0, "R6", "status cleared by W1C", v, 0);
      chk(irq == 1'b0, "R7", "irq after clear", int'(irq), 0);
      waitc(6 * DIV);
      rd(4'h9, v); chk(v == 0, "R6", "no retrigger on held level", v, 0);

      // R5 fall on trig-high channel: level changes, no status
      drive_exp(0, 0, 3);
      waitc(5 * DIV);
      rd(4'h9, v); chk(v == 0, "R5", "no status on non-trigger level", v, 0);
      drive_exp(0, 1, 3);
      waitc(5 * DIV);

      // R2 / R4: window value 0 on ch1, sub-ms pulses at shifting phases
      wr(4'h9, 14'h000F);
      wr(4'h1, 14'h3000);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk); in_async[1] = 1'b1;
         waitc(DIV - 2);
         in_async[1] = 1'b0;
         waitc(DIV + 3);
      end
      waitc(3 * DIV);
      chk(stable_lvl[1] == 1'b0, "R2", "short pulses ignored (level)", int'(stable_lvl[1]), 0);
      rd(4'h9, v); chk((v & 2) == 0, "R4", "zero window behaves as 1 ms", v & 2, 0);
      drive_exp(1, 1, 1);
      waitc(3 * DIV);
      rd(4'h9, v); chk((v & 2) == 2, "R4", "zero-window channel qualifies", v & 2, 2);

      // R3 restart on ch2, window 4 ms
      wr(4'h2, 14'h3004);
      @(negedge clk); in_async[2] = 1'b1;
      waitc(25);
      in_async[2] = 1'b0;
      waitc(3);
      drive_exp(2, 1, 4);
      waitc(6 * DIV);
      rd(4'h9, v); chk((v & 4) == 4, "R3", "restarted window qualifies", v & 4, 4);

      // R5 trigger low on ch3
      wr(4'h9, 14'h000F);
      wr(4'h3, 14'h2002);
      drive_exp(3, 1, 2);
      waitc(4 * DIV);
      rd(4'h9, v); chk((v & 8) == 0, "R5", "rise ignored on trig-low", v & 8, 0);
      drive_exp(3, 0, 2);
      waitc(4 * DIV);
      rd(4'h9, v); chk(v == 8, "R5", "fall sets trig-low status", v, 8);

      // R7 mask
      wr(4'h8, 14'h0007);
      waitc(2);
      chk(irq == 1'b0, "R7", "irq masked off", int'(irq), 0);
      wr(4'h8, 14'h000F);
      waitc(2);
      chk(irq == 1'b1, "R7", "irq unmasked", int'(irq), 1);

      // R8 disabled channel keeps level
      wr(4'h9, 14'h000F);
      wr(4'h2, 14'h1004);
      @(negedge clk); in_async[2] = 1'b0;
      waitc(6 * DIV);
      chk(stable_lvl[2] == 1'b1, "R8", "disabled channel holds level", int'(stable_lvl[2]), 1);
      rd(4'h9, v); chk(v == 0, "R8", "disabled channel no status", v, 0);
      chk(clk_off_req == 1'b1, "R9", "disabled channel difference allows clock off", int'(clk_off_req), 1);

      // R4 clamp: 4095 behaves as 4000 ms
      @(negedge clk);
      push_exp(2, 0, 4000);
      wr(4'h2, 14'h3FFF);
      waitc(4002 * DIV);
      chk(stable_lvl[2] == 1'b0, "R4", "clamped window completed", int'(stable_lvl[2]), 0);

      waitc(5);
      chk(sb.size() == 0, "R1", "all expected changes seen", sb.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule